// File: doc/BRIEF.md
# Instruction Fetch PC Sequencer

This block is the first stage of a small in-order 32-bit pipeline. It keeps the program counter and drives it straight onto the address of a synchronous instruction memory. Without any other request it steps the counter forward by one 4-byte instruction each cycle. The memory returns the addressed word on the following clock. The block tags that word with the address it came from and a valid bit, and together they form the IF/ID pipeline register that the decode stage reads.

The decode stage controls the block with two signals. A redirect, raised when decode resolves a taken branch or a jump, loads the supplied target into the counter. The one word that was fetched along the wrong path in that cycle is marked invalid, so it becomes a single bubble. A stall freezes the counter and the IF/ID register. It also drops the memory read enable, so the memory keeps its output word. A redirect wins over a stall raised in the same cycle.

Top module: `fetch_seq`

## Requirements
- R1: In the cycle after a cycle with `rst` high, `imem_addr_o` equals the parameter `RESET_VEC` and `ifid_valid_o` is 0.
- R2: After a cycle with `stall_i` and `redirect_i` both low, `imem_addr_o` equals its previous value plus 4.
- R3: `imem_addr_o` always shows the current program counter. `imem_en_o` is 0 exactly in cycles where `stall_i` is 1 and `redirect_i` is 0. The memory returns the word for the enabled address on the next clock and holds its output while not enabled.
- R4: After a cycle with `stall_i` and `redirect_i` both low, `ifid_valid_o` is 1. `ifid_pc_o` then holds the address presented in that cycle, and `ifid_instr_o` holds the word stored at that address.
- R5: After a cycle with `redirect_i` high, `imem_addr_o` equals `redirect_target_i` from that cycle with bits [1:0] cleared.
- R6: After a cycle with `redirect_i` high, `ifid_valid_o` is 0. The word at the target address shows up valid in `ifid_pc_o` two cycles after the redirect, provided no stall intervenes, so the penalty is one bubble.
- R7: After a cycle with `stall_i` high and `redirect_i` low, `imem_addr_o`, `ifid_valid_o`, `ifid_pc_o` and `ifid_instr_o` are unchanged.
- R8: When `stall_i` and `redirect_i` are both high, the redirect is performed exactly as in R5 and R6, and the stall has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Freeze request from decode |
| redirect_i | input | 1 | Taken branch or jump resolved in decode |
| redirect_target_i | input | 32 | Byte address of the redirect destination |
| imem_en_o | output | 1 | Instruction memory read enable |
| imem_addr_o | output | 32 | Instruction memory byte address (the PC) |
| imem_rdata_i | input | 32 | Word returned by the memory one cycle after the address |
| ifid_valid_o | output | 1 | IF/ID entry holds a real instruction |
| ifid_pc_o | output | 32 | Address of the IF/ID instruction |
| ifid_instr_o | output | 32 | IF/ID instruction word |

## Verification
The bench targets these cases:
- A long stall, including one that starts on a bubble. If the memory enable were left high, the held word would be replaced by the next one. If the register were not frozen, the PC would move on.
- A redirect in the same cycle as a stall. A design that gave the stall priority would lose the branch and keep fetching sequentially.
- Back-to-back redirects and an unaligned target. A missing bubble would let a wrong-path word through as valid. A target that was not masked would put a misaligned address on the memory port.
- Long random runs of stalls, redirects and plain steps. These cover orders of events that the directed cases miss.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int XLEN        = 32;
    localparam int ILEN        = 32;
    localparam int INSTR_BYTES = ILEN / 8;

    typedef logic [XLEN-1:0] addr_t;
    typedef logic [ILEN-1:0] word_t;

    typedef enum logic [1:0] {
        NPC_SEQ   = 2'd0,
        NPC_HOLD  = 2'd1,
        NPC_REDIR = 2'd2
    } npc_sel_e;

    typedef struct packed {
        addr_t pc;
        logic  valid;
    } fetch_tag_t;

    function automatic addr_t seq_next(input addr_t pc);
        return pc + addr_t'(INSTR_BYTES);
    endfunction

    function automatic addr_t align_addr(input addr_t a);
        return a & ~addr_t'(INSTR_BYTES - 1);
    endfunction

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
    import fetch_pkg::*;
(
    input  logic     stall_i,
    input  logic     redirect_i,
    output npc_sel_e sel_o,
    output logic     mem_en_o,
    output logic     tag_load_o,
    output logic     tag_valid_o
);
    // redirect outranks stall
    always_comb begin
        if (redirect_i)   sel_o = NPC_REDIR;
        else if (stall_i) sel_o = NPC_HOLD;
        else              sel_o = NPC_SEQ;
    end

    always_comb begin
        mem_en_o    = (sel_o != NPC_HOLD);
        tag_load_o  = (sel_o != NPC_HOLD);
        tag_valid_o = (sel_o == NPC_SEQ);
    end
endmodule

// File: rtl/fetch_npc.sv
module fetch_npc
    import fetch_pkg::*;
(
    input  addr_t    pc_i,
    input  addr_t    target_i,
    input  npc_sel_e sel_i,
    output addr_t    npc_o
);
    always_comb begin
        unique case (sel_i)
            NPC_REDIR: npc_o = align_addr(target_i);
            NPC_HOLD:  npc_o = pc_i;
            default:   npc_o = seq_next(pc_i);
        endcase
    end
endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg
    import fetch_pkg::*;
#(
    parameter addr_t RESET_VEC = 32'h0000_1000
) (
    input  logic  clk,
    input  logic  rst,
    input  addr_t npc_i,
    output addr_t pc_o
);
    always_ff @(posedge clk) begin
        if (rst) pc_o <= RESET_VEC;
        else     pc_o <= npc_i;
    end
endmodule

// File: rtl/fetch_tag_reg.sv
module fetch_tag_reg
    import fetch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  fetch_tag_t tag_i,
    output fetch_tag_t tag_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tag_o.valid <= 1'b0;
            tag_o.pc    <= '0;
        end else if (load_i) begin
            tag_o <= tag_i;
        end
    end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
    import fetch_pkg::*;
#(
    parameter addr_t RESET_VEC = 32'h0000_1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        stall_i,
    input  logic        redirect_i,
    input  logic [31:0] redirect_target_i,
    output logic        imem_en_o,
    output logic [31:0] imem_addr_o,
    input  logic [31:0] imem_rdata_i,
    output logic        ifid_valid_o,
    output logic [31:0] ifid_pc_o,
    output logic [31:0] ifid_instr_o
);
    npc_sel_e   sel;
    addr_t      pc_q;
    addr_t      npc;
    logic       tag_load;
    logic       tag_valid;
    fetch_tag_t tag_d;
    fetch_tag_t tag_q;

    fetch_ctrl u_ctrl (
        .stall_i     (stall_i),
        .redirect_i  (redirect_i),
        .sel_o       (sel),
        .mem_en_o    (imem_en_o),
        .tag_load_o  (tag_load),
        .tag_valid_o (tag_valid)
    );

    fetch_npc u_npc (
        .pc_i     (pc_q),
        .target_i (redirect_target_i),
        .sel_i    (sel),
        .npc_o    (npc)
    );

    fetch_pc_reg #(.RESET_VEC(RESET_VEC)) u_pc (
        .clk   (clk),
        .rst   (rst),
        .npc_i (npc),
        .pc_o  (pc_q)
    );

    always_comb begin
        tag_d.pc    = pc_q;
        tag_d.valid = tag_valid;
    end

    fetch_tag_reg u_tag (
        .clk    (clk),
        .rst    (rst),
        .load_i (tag_load),
        .tag_i  (tag_d),
        .tag_o  (tag_q)
    );

    // the memory output register is the instruction half of IF/ID
    assign imem_addr_o  = pc_q;
    assign ifid_valid_o = tag_q.valid;
    assign ifid_pc_o    = tag_q.pc;
    assign ifid_instr_o = imem_rdata_i;
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk
    import fetch_pkg::*;
#(
    parameter addr_t RESET_VEC = 32'h0000_1000
) (
    input logic        clk,
    input logic        rst,
    input logic        stall_i,
    input logic        redirect_i,
    input logic [31:0] redirect_target_i,
    input logic        imem_en_o,
    input logic [31:0] imem_addr_o,
    input logic        ifid_valid_o,
    input logic [31:0] ifid_pc_o
);
    localparam addr_t MASK = ~addr_t'(INSTR_BYTES - 1);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (imem_addr_o == RESET_VEC && !ifid_valid_o));

    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && !redirect_i) |=> imem_addr_o == $past(imem_addr_o) + addr_t'(INSTR_BYTES));

    p_en_low_r3: assert property (@(posedge clk) disable iff (rst)
        (stall_i && !redirect_i) |-> !imem_en_o);

    p_en_high_r3: assert property (@(posedge clk) disable iff (rst)
        redirect_i |-> imem_en_o);

    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && !redirect_i) |=> (ifid_valid_o && ifid_pc_o == $past(imem_addr_o)));

    p_target_r5: assert property (@(posedge clk) disable iff (rst)
        redirect_i |=> imem_addr_o == ($past(redirect_target_i) & MASK));

    p_bubble_r6: assert property (@(posedge clk) disable iff (rst)
        redirect_i |=> !ifid_valid_o);

    p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        (stall_i && !redirect_i) |=>
            ($stable(imem_addr_o) && $stable(ifid_valid_o) && $stable(ifid_pc_o)));

    p_prio_r8: assert property (@(posedge clk) disable iff (rst)
        (stall_i && redirect_i) |=>
            (!ifid_valid_o && imem_addr_o == ($past(redirect_target_i) & MASK)));
endmodule

bind fetch_seq fetch_seq_chk #(.RESET_VEC(RESET_VEC)) u_chk (.*);

// File: tb/fetch_seq_tb.sv
module fetch_seq_tb;
    localparam logic [31:0] RV = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall_i = 1'b0;
    logic        redirect_i = 1'b0;
    logic [31:0] redirect_target_i = '0;
    logic        imem_en_o;
    logic [31:0] imem_addr_o;
    logic [31:0] imem_rdata_i = '0;
    logic        ifid_valid_o;
    logic [31:0] ifid_pc_o;
    logic [31:0] ifid_instr_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] e_pc;
    logic        e_valid;
    logic [31:0] e_ifpc;

    always #10 clk = ~clk;

    fetch_seq #(.RESET_VEC(RV)) u_dut (.*);

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h5A3C_0F00;
    endfunction

    // synchronous memory model: word one clock later, held while not enabled (R3)
    always @(posedge clk) if (imem_en_o) imem_rdata_i <= word_at(imem_addr_o);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        chk({req, " addr"},  imem_addr_o, e_pc);
        chk({req, " valid"}, {31'd0, ifid_valid_o}, {31'd0, e_valid});
        if (e_valid) begin
            chk({req, " ifid_pc R4"},    ifid_pc_o, e_ifpc);
            chk({req, " ifid_instr R4"}, ifid_instr_o, word_at(e_ifpc));
        end
    endtask

    // called at a negedge: check, drive, advance one clock, update model
    task automatic step(input logic s, input logic r, input logic [31:0] t, input string req);
        check_state(req);
        stall_i = s;
        redirect_i = r;
        redirect_target_i = t;
        #1;
        chk({req, " en R3"}, {31'd0, imem_en_o}, {31'd0, (!s || r)});
        @(posedge clk);
        if (r) begin
            e_valid = 1'b0;
            e_ifpc  = e_pc;
            e_pc    = t & ~32'd3;
        end else if (!s) begin
            e_valid = 1'b1;
            e_ifpc  = e_pc;
            e_pc    = e_pc + 32'd4;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset addr", imem_addr_o, RV);
        chk("R1 reset valid", {31'd0, ifid_valid_o}, 32'd0);
        rst = 1'b0;
        e_pc = RV; e_valid = 1'b0; e_ifpc = RV;

        // straight-line code (R2, R4)
        for (int i = 0; i < 6; i++) step(0, 0, 0, "R2");
        chk("R2 after six steps", imem_addr_o, RV + 32'd24);

        // taken branch with one bubble (R5, R6)
        step(0, 1, 32'h0000_2000, "R5");
        chk("R6 bubble", {31'd0, ifid_valid_o}, 32'd0);
        chk("R5 target", imem_addr_o, 32'h0000_2000);
        step(0, 0, 0, "R6");
        chk("R6 target word valid", ifid_pc_o, 32'h0000_2000);

        // multi-cycle stall (R7)
        step(0, 0, 0, "R2");
        for (int i = 0; i < 4; i++) begin
            step(1, 0, 0, "R7");
            chk("R7 held instr", ifid_instr_o, word_at(32'h0000_2004));
        end
        step(0, 0, 0, "R7 release");

        // stall and redirect together (R8), unaligned target (R5)
        step(1, 1, 32'h0000_3007, "R8");
        chk("R8 redirect wins", imem_addr_o, 32'h0000_3004);
        chk("R8 bubble", {31'd0, ifid_valid_o}, 32'd0);

        // stall on a bubble, then back-to-back redirects (R6, R7)
        step(1, 0, 0, "R7 bubble hold");
        step(0, 1, 32'h0000_4000, "R6");
        step(0, 1, 32'h0000_5000, "R6");
        step(0, 0, 0, "R6");
        step(0, 0, 0, "R4");

        // constrained random mix
        for (int i = 0; i < 2000; i++) begin
            logic s, r;
            logic [31:0] t;
            s = ($urandom_range(3) == 0);
            r = ($urandom_range(5) == 0);
            t = $urandom & 32'h000F_FFFF;
            step(s, r, t, "R2/R4/R5/R7 random");
        end
        check_state("final");

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule